// File: doc/BRIEF.md
# Banyan Self-Routing Switch Fabric

This block moves a set of up to N = 2^K packets from N input lines to N output lines with no central scheduler. Each packet carries a valid flag, a K-bit destination tag and a payload. The packet passes through K stages of 2×2 steering elements. Each stage looks at one tag bit and sends the packet toward the upper or lower line of its element, so after the last stage a packet with tag x sits on output line x. The tag is consumed inside the fabric and only the payload leaves it.

Two packets can reach one element and ask for the same side. The fabric does not buffer or retry in that case. It keeps the packet from the element's upper input, drops the other one, and raises a blocked flag for that stage. The flag travels with the packet set, so the caller sees which stages lost traffic in the same cycle that the set comes out. Every stage is registered. The fabric therefore takes a new packet set on each clock and returns it K cycles later. An upstream sorter that presents packets in ascending tag order on consecutive lines starting at line 0 gets loss-free delivery.

Top module: `banyan_fabric`

## Requirements
- R1: After reset, and for as long as reset is held, out_valid is all zeros and out_blocked is all zeros.
- R2: A packet set applied in the cycle before rising edge t appears on the outputs after edge t+K-1, that is K cycles later. A new set is accepted on every cycle, and back-to-back sets do not interfere.
- R3: Input line l carries its tag in in_tag[l*K +: K] and its payload in in_payload[l*PW +: PW]. A valid packet with tag x that is not dropped appears at output line x, with out_valid[x] set and the payload unchanged in out_payload[x*PW +: PW]. The tag is not driven out.
- R4: Stage s (s = 0 is the first stage) examines tag bit K-1-s. Its elements pair line l (bit K-1-s clear) with line l + 2^(K-1-s). A packet whose examined bit is 0 continues on line l (the upper line). A packet whose examined bit is 1 continues on the paired line (the lower line).
- R5: When both packets at an element are valid and their examined bits are equal, the packet from the lower-numbered line goes on, the other is dropped, and out_blocked[s] is set for that packet set. In every other case out_blocked[s] stays 0.
- R6: A cycle with no valid input yields, K cycles later, no valid output and out_blocked all zeros.
- R7: If the valid packets carry distinct tags in ascending order on lines 0 to m-1, every packet is delivered and out_blocked is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | N | Per-line valid flag of the incoming set |
| in_tag | input | N*K | Per-line destination tag, line l at bits [l*K +: K] |
| in_payload | input | N*PW | Per-line payload, line l at bits [l*PW +: PW] |
| out_valid | output | N | Per-line valid flag of the delivered set |
| out_payload | output | N*PW | Per-line payload with the tag removed |
| out_blocked | output | K | Bit s set when stage s dropped a packet of this set |

## Verification
Every result of a packet set, meaning valid lines, payloads and blocked flags, is due exactly K cycles after the set is applied. When the bench drives a set, it stamps the expected result with the cycle number at which the result must appear. The monitor compares the outputs only at the falling edge of that exact cycle, so an early or late result counts as a mismatch. Because the driver also pushes an expected entry for idle cycles, the outputs are compared in every cycle after the first set.

// File: rtl/banyan_pkg.sv
package banyan_pkg;

  // Distance between the two lines that an element of stage s joins.
  function automatic int unsigned span_of(input int unsigned k, input int unsigned s);
    return 1 << (k - 1 - s);
  endfunction

  // Tag bit examined by stage s.
  function automatic int unsigned exam_bit(input int unsigned k, input int unsigned s);
    return k - 1 - s;
  endfunction

  // Lower-numbered (upper) line of element e in stage s.
  function automatic int unsigned upper_line(input int unsigned k, input int unsigned s,
                                             input int unsigned e);
    int unsigned d;
    d = span_of(k, s);
    return (e / d) * 2 * d + (e % d);
  endfunction

endpackage

// File: rtl/banyan_elem.sv
module banyan_elem #(
  parameter int unsigned TW  = 3,
  parameter int unsigned PW  = 8,
  parameter int unsigned SEL = 0
) (
  input  logic          a_v,
  input  logic [TW-1:0] a_tag,
  input  logic [PW-1:0] a_pay,
  input  logic          b_v,
  input  logic [TW-1:0] b_tag,
  input  logic [PW-1:0] b_pay,
  output logic          up_v,
  output logic [TW-1:0] up_tag,
  output logic [PW-1:0] up_pay,
  output logic          dn_v,
  output logic [TW-1:0] dn_tag,
  output logic [PW-1:0] dn_pay,
  output logic          clash
);

  logic a_bit, b_bit;
  logic a_up, a_dn, b_up, b_dn;

  always_comb begin
    a_bit  = a_tag[SEL];
    b_bit  = b_tag[SEL];
    // upper input has priority on the side it asks for
    a_up   = a_v & ~a_bit;
    a_dn   = a_v &  a_bit;
    b_up   = b_v & ~b_bit & ~a_up;
    b_dn   = b_v &  b_bit & ~a_dn;
    clash  = a_v & b_v & (a_bit == b_bit);
    up_v   = a_up | b_up;
    up_tag = a_up ? a_tag : b_tag;
    up_pay = a_up ? a_pay : b_pay;
    dn_v   = a_dn | b_dn;
    dn_tag = a_dn ? a_tag : b_tag;
    dn_pay = a_dn ? a_pay : b_pay;
  end

endmodule

// File: rtl/banyan_stage.sv
module banyan_stage
  import banyan_pkg::*;
#(
  parameter int unsigned K  = 3,
  parameter int unsigned PW = 8,
  parameter int unsigned S  = 0,
  parameter int unsigned N  = 1 << K
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  in_v,
  input  logic [K-1:0]  in_tag [N],
  input  logic [PW-1:0] in_pay [N],
  input  logic [K-1:0]  in_blk,
  output logic [N-1:0]  out_v,
  output logic [K-1:0]  out_tag [N],
  output logic [PW-1:0] out_pay [N],
  output logic [K-1:0]  out_blk
);

  localparam int unsigned HALF = N / 2;
  localparam int unsigned BSEL = exam_bit(K, S);
  localparam int unsigned DIST = span_of(K, S);
  localparam int unsigned CW   = $clog2(N + 1);

  logic [N-1:0]    nx_v;
  logic [K-1:0]    nx_tag [N];
  logic [PW-1:0]   nx_pay [N];
  logic [HALF-1:0] clash;
  logic [K-1:0]    blk_nx;
  logic [CW-1:0]   survive_d, survive_q;

  for (genvar e = 0; e < HALF; e++) begin : g_elem
    localparam int unsigned LO = upper_line(K, S, e);
    localparam int unsigned HI = LO + DIST;
    banyan_elem #(.TW(K), .PW(PW), .SEL(BSEL)) u_elem (
      .a_v   (in_v[LO]),   .a_tag (in_tag[LO]), .a_pay (in_pay[LO]),
      .b_v   (in_v[HI]),   .b_tag (in_tag[HI]), .b_pay (in_pay[HI]),
      .up_v  (nx_v[LO]),   .up_tag(nx_tag[LO]), .up_pay(nx_pay[LO]),
      .dn_v  (nx_v[HI]),   .dn_tag(nx_tag[HI]), .dn_pay(nx_pay[HI]),
      .clash (clash[e])
    );
  end

  always_comb begin
    blk_nx    = in_blk;
    blk_nx[S] = in_blk[S] | (|clash);
  end

  // packets expected to leave this stage: arrivals minus one per clash
  assign survive_d = CW'($countones(in_v)) - CW'($countones(clash));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_v     <= '0;
      out_blk   <= '0;
      survive_q <= '0;
    end else begin
      out_v     <= nx_v;
      out_blk   <= blk_nx;
      survive_q <= survive_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < N; l++) begin
      out_tag[l] <= nx_tag[l];
      out_pay[l] <= nx_pay[l];
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (out_v == '0 && out_blk == '0));

  // R5
  pkt_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(out_v) == int'(survive_q));

  for (genvar l = 0; l < N; l++) begin : g_route
    localparam bit LBIT = ((l >> BSEL) & 1) == 1;
    // R4
    route_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_v[l] |-> (out_tag[l][BSEL] == LBIT));
  end

endmodule

// File: rtl/banyan_fabric.sv
module banyan_fabric
  import banyan_pkg::*;
#(
  parameter int unsigned K  = 3,
  parameter int unsigned PW = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [(1<<K)-1:0]       in_valid,
  input  logic [(1<<K)*K-1:0]     in_tag,
  input  logic [(1<<K)*PW-1:0]    in_payload,
  output logic [(1<<K)-1:0]       out_valid,
  output logic [(1<<K)*PW-1:0]    out_payload,
  output logic [K-1:0]            out_blocked
);

  localparam int unsigned N = 1 << K;

  logic [N-1:0]  v_bus   [K+1];
  logic [K-1:0]  tag_bus [K+1][N];
  logic [PW-1:0] pay_bus [K+1][N];
  logic [K-1:0]  blk_bus [K+1];

  assign v_bus[0]   = in_valid;
  assign blk_bus[0] = '0;

  for (genvar l = 0; l < N; l++) begin : g_lines
    assign tag_bus[0][l]           = in_tag[l*K +: K];
    assign pay_bus[0][l]           = in_payload[l*PW +: PW];
    assign out_payload[l*PW +: PW] = pay_bus[K][l];
  end

  for (genvar s = 0; s < K; s++) begin : g_stage
    banyan_stage #(.K(K), .PW(PW), .S(s), .N(N)) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_v    (v_bus[s]),
      .in_tag  (tag_bus[s]),
      .in_pay  (pay_bus[s]),
      .in_blk  (blk_bus[s]),
      .out_v   (v_bus[s+1]),
      .out_tag (tag_bus[s+1]),
      .out_pay (pay_bus[s+1]),
      .out_blk (blk_bus[s+1])
    );
  end

  assign out_valid   = v_bus[K];
  assign out_blocked = blk_bus[K];

  for (genvar x = 0; x < N; x++) begin : g_dest
    // R3
    dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[x] |-> (tag_bus[K][x] == K'(x)));
  end

endmodule

// File: tb/banyan_fabric_tb_top.sv
`timescale 1ns/1ps
module banyan_fabric_tb_top;

  localparam int K  = 3;
  localparam int N  = 1 << K;
  localparam int PW = 8;

  typedef struct {
    logic [N-1:0]    v;
    logic [N*PW-1:0] pay;
    logic [K-1:0]    blk;
    int              due;
    string           req;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    in_valid = '0;
  logic [N*K-1:0]  in_tag = '0;
  logic [N*PW-1:0] in_payload = '0;
  logic [N-1:0]    out_valid;
  logic [N*PW-1:0] out_payload;
  logic [K-1:0]    out_blocked;

  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  exp_t sb[$];

  banyan_fabric #(.K(K), .PW(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
    .in_payload(in_payload), .out_valid(out_valid),
    .out_payload(out_payload), .out_blocked(out_blocked)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Reference: stage by stage, pairs at distance 2^(K-1-s), lower line first.
  task automatic model(input logic [N-1:0] iv, input logic [N*K-1:0] it,
                       input logic [N*PW-1:0] ip, output exp_t e);
    logic [N-1:0]  cv, nv;
    logic [K-1:0]  ct [N];
    logic [K-1:0]  nt [N];
    logic [PW-1:0] cp [N];
    logic [PW-1:0] np [N];
    e.blk = '0;
    e.pay = '0;
    cv = iv;
    for (int l = 0; l < N; l++) begin
      ct[l] = it[l*K +: K];
      cp[l] = ip[l*PW +: PW];
    end
    for (int s = 0; s < K; s++) begin
      int b;
      int d;
      b = K - 1 - s;
      d = 1 << b;
      nv = '0;
      for (int l = 0; l < N; l++) begin
        nt[l] = '0;
        np[l] = '0;
      end
      for (int l = 0; l < N; l++) begin
        if (((l >> b) & 1) == 0) begin
          int h;
          int dst;
          h = l + d;
          if (cv[l]) begin
            dst = ct[l][b] ? h : l;
            nv[dst] = 1'b1; nt[dst] = ct[l]; np[dst] = cp[l];
          end
          if (cv[h]) begin
            dst = ct[h][b] ? h : l;
            if (nv[dst]) e.blk[s] = 1'b1;
            else begin
              nv[dst] = 1'b1; nt[dst] = ct[h]; np[dst] = cp[h];
            end
          end
        end
      end
      cv = nv;
      ct = nt;
      cp = np;
    end
    e.v = cv;
    for (int l = 0; l < N; l++) e.pay[l*PW +: PW] = cv[l] ? cp[l] : '0;
  endtask

  // Driver: apply one set at a falling edge and push what is due K cycles on.
  task automatic push_set(input logic [N-1:0] iv, input logic [N*K-1:0] it,
                          input logic [N*PW-1:0] ip, input exp_t e, input string req);
    @(negedge clk);
    in_valid = iv;
    in_tag = it;
    in_payload = ip;
    e.due = cyc + K;
    e.req = req;
    sb.push_back(e);
  endtask

  task automatic send(input logic [N-1:0] iv, input logic [N*K-1:0] it,
                      input logic [N*PW-1:0] ip, input string req);
    exp_t e;
    model(iv, it, ip, e);
    push_set(iv, it, ip, e, req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) send('0, '0, '0, "R6");
  endtask

  // Monitor: compare in exactly the cycle a result is due.
  always @(negedge clk) begin
    exp_t e;
    logic [N*PW-1:0] mask;
    if (sb.size() > 0 && sb[0].due == cyc) begin
      e = sb.pop_front();
      mask = '0;
      for (int l = 0; l < N; l++) if (e.v[l]) mask[l*PW +: PW] = '1;
      check(out_valid == e.v, e.req, "out_valid", 64'(out_valid), 64'(e.v));
      check((out_payload & mask) == (e.pay & mask), e.req, "out_payload",
            64'(out_payload & mask), 64'(e.pay & mask));
      check(out_blocked == e.blk, e.req, "out_blocked", 64'(out_blocked), 64'(e.blk));
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0]    iv;
    logic [N*K-1:0]  it;
    logic [N*PW-1:0] ip;
    exp_t            e;

    // R1: held in reset across several edges
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(out_valid == '0, "R1", "out_valid in reset", 64'(out_valid), 64'd0);
    check(out_blocked == '0, "R1", "out_blocked in reset", 64'(out_blocked), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == '0, "R1", "out_valid after reset", 64'(out_valid), 64'd0);
    check(out_blocked == '0, "R1", "out_blocked after reset", 64'(out_blocked), 64'd0);

    // R3 / R4: single packets, hand-written expectations
    for (int l = 0; l < N; l++) begin
      int t;
      t = (l * 3 + 5) % N;
      iv = '0; it = '0; ip = '0;
      iv[l] = 1'b1;
      it[l*K +: K] = K'(t);
      ip[l*PW +: PW] = PW'(8'h30 + l);
      e.v = '0; e.pay = '0; e.blk = '0;
      e.v[t] = 1'b1;
      e.pay[t*PW +: PW] = PW'(8'h30 + l);
      push_set(iv, it, ip, e, "R3");
      idle(K);
    end

    // R7: identity set, full load
    iv = '1; it = '0; ip = '0;
    e.v = '1; e.pay = '0; e.blk = '0;
    for (int l = 0; l < N; l++) begin
      it[l*K +: K] = K'(l);
      ip[l*PW +: PW] = PW'(8'h10 + l);
      e.pay[l*PW +: PW] = PW'(8'h10 + l);
    end
    push_set(iv, it, ip, e, "R7");

    // R7: ascending tags 1,4,6 on lines 0..2
    iv = 8'b0000_0111; it = '0; ip = '0;
    it[0*K +: K] = 3'd1; ip[0*PW +: PW] = 8'hA1;
    it[1*K +: K] = 3'd4; ip[1*PW +: PW] = 8'hA4;
    it[2*K +: K] = 3'd6; ip[2*PW +: PW] = 8'hA6;
    e.v = 8'b0101_0010; e.pay = '0; e.blk = '0;
    e.pay[1*PW +: PW] = 8'hA1;
    e.pay[4*PW +: PW] = 8'hA4;
    e.pay[6*PW +: PW] = 8'hA6;
    push_set(iv, it, ip, e, "R7");
    idle(K);

    // R5: clash in the first stage, lines 0 and 4 (tags 1 and 2), line 0 wins -> out 1
    iv = 8'b0001_0001; it = '0; ip = '0;
    it[0*K +: K] = 3'd1; ip[0*PW +: PW] = 8'h5A;
    it[4*K +: K] = 3'd2; ip[4*PW +: PW] = 8'hC3;
    e.v = 8'b0000_0010; e.pay = '0; e.blk = 3'b001;
    e.pay[1*PW +: PW] = 8'h5A;
    push_set(iv, it, ip, e, "R5");

    // R5: clash only in the last stage, lines 0 and 1 both tag 3, line 0 wins
    iv = 8'b0000_0011; it = '0; ip = '0;
    it[0*K +: K] = 3'd3; ip[0*PW +: PW] = 8'h55;
    it[1*K +: K] = 3'd3; ip[1*PW +: PW] = 8'h66;
    e.v = 8'b0000_1000; e.pay = '0; e.blk = 3'b100;
    e.pay[3*PW +: PW] = 8'h55;
    push_set(iv, it, ip, e, "R5");
    idle(K + 1);

    // R2: back-to-back sets, each due exactly K cycles after it was applied
    for (int i = 0; i < 12; i++) begin
      iv = '1; it = '0; ip = '0;
      for (int l = 0; l < N; l++) begin
        it[l*K +: K] = K'((l + i) % N);
        ip[l*PW +: PW] = PW'(i * 16 + l);
      end
      send(iv, it, ip, "R2");
    end
    idle(K);

    // R5 / R3: random sets against the reference
    for (int i = 0; i < 400; i++) begin
      iv = N'($urandom);
      it = (N*K)'($urandom);
      ip = {$urandom, $urandom};
      send(iv, it, ip, "R5");
    end
    idle(K + 2);

    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule